// File: doc/BRIEF.md
# Bit-Slice Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a 32-bit integer datapath. It takes two operands and a 4-bit operation code and returns a result word together with three flags: a zero indication, the carry leaving the top bit, and signed overflow. It performs bitwise AND, OR and NOR, two's-complement addition and subtraction, and a signed less-than comparison. The design builds the word from a row of identical 1-bit slices. Each slice can invert either operand and contains an AND gate, an OR gate and a full adder. A small multiplexer in the slice then picks one of these results.

The operation code is split into fields that drive the slices directly. Bit 3 inverts operand a and bit 2 inverts operand b. Bit 2 also feeds a carry of 1 into bit 0. Bits 1:0 select what each slice returns: 00 AND, 01 OR, 10 sum, 11 the less-than input. Subtraction, NOR and the comparison therefore need no dedicated hardware. Subtraction is a plus the inverse of b plus one. NOR is the AND of both inverted operands. The comparison takes the sign of a minus b from the top slice, corrects it for overflow, and routes it into bit 0. A control decoder turns the code into a few strobes for the slice row. Codes outside the supported set are forced to a zero result.

Top module: `alu_core`

## Requirements
- R1: Code 4'b0000 returns the bitwise AND of a and b.
- R2: Code 4'b0001 returns the bitwise OR of a and b.
- R3: Code 4'b0010 returns a + b modulo 2^32, and carryOut is the carry out of bit 31 of that sum.
- R4: Code 4'b0110 returns a - b modulo 2^32, computed as a + ~b + 1. carryOut is the carry out of bit 31 of that sum, which is 1 exactly when a >= b as unsigned values.
- R5: Code 4'b0111 returns 32'd1 when a < b as signed two's-complement values and 32'd0 otherwise. Bits 31:1 are always 0, including when a - b overflows.
- R6: Code 4'b1100 returns the bitwise NOR of a and b.
- R7: zeroFlag is 1 exactly when all 32 result bits are 0. With code 4'b0110 it is therefore 1 exactly when a equals b.
- R8: With codes 4'b0010 and 4'b0110, overflow is 1 exactly when the signed result does not fit in 32 bits. This equals the carry into bit 31 xor the carry out of bit 31.
- R9: Any code other than the six above returns a zero result, with carryOut and overflow both 0.
- R10: With codes 4'b0000, 4'b0001, 4'b0111 and 4'b1100, carryOut and overflow are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| opCode | input | 4 | Operation code: bit 3 inverts a, bit 2 inverts b and sets the carry-in, bits 1:0 select the slice output |
| result | output | 32 | Operation result |
| zeroFlag | output | 1 | High when result is all zeros |
| carryOut | output | 1 | Carry out of bit 31 for add and subtract, else 0 |
| overflow | output | 1 | Signed overflow for add and subtract, else 0 |

## Verification
The comparison gets the most attention. The bench uses operand pairs whose difference overflows, such as the most negative value against the most positive. A design that took the raw adder sign would report the opposite answer there. Carry propagation across all 32 bits is tested by adding one to all-ones, which should give zero with carry set; a broken chain leaves stray high bits and no carry. Subtraction of equal values checks the zero flag. Undecoded codes are swept so that a decoder falling back to a real operation, or leaking carry and overflow from the adder, shows up as a nonzero result or a raised flag.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } sel_e;

  localparam logic [3:0] OP_AND = 4'b0000;
  localparam logic [3:0] OP_OR  = 4'b0001;
  localparam logic [3:0] OP_ADD = 4'b0010;
  localparam logic [3:0] OP_SUB = 4'b0110;
  localparam logic [3:0] OP_SLT = 4'b0111;
  localparam logic [3:0] OP_NOR = 4'b1100;

  // Strobes from the decoder to the slice row
  typedef struct packed {
    logic invA;
    logic invB;
    logic carryIn;
    sel_e sel;
    logic opValid;
    logic arith;
  } ctrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] opCode,
  output ctrl_t      strobes
);

  always_comb begin
    strobes = '0;
    case (opCode)
      OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NOR: begin
        strobes.invA    = opCode[3];
        strobes.invB    = opCode[2];
        strobes.carryIn = opCode[2];
        strobes.sel     = sel_e'(opCode[1:0]);
        strobes.opValid = 1'b1;
        strobes.arith   = (opCode[1:0] == 2'b10);
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic invA,
  input  logic invB,
  input  logic carryIn,
  input  logic less,
  input  sel_e sel,
  output logic sum,
  output logic carryOut,
  output logic result
);

  logic aEff;
  logic bEff;

  assign aEff     = a ^ invA;
  assign bEff     = b ^ invB;
  assign sum      = aEff ^ bEff ^ carryIn;
  assign carryOut = (aEff & bEff) | (aEff & carryIn) | (bEff & carryIn);

  always_comb begin
    case (sel)
      SEL_AND:  result = aEff & bEff;
      SEL_OR:   result = aEff | bEff;
      SEL_SUM:  result = sum;
      SEL_LESS: result = less;
      default:  result = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  ctrl_t        strobes,
  output logic [W-1:0] result,
  output logic         zeroFlag,
  output logic         carryOut,
  output logic         overflow
);

  localparam int MSB = W - 1;

  logic [W-1:0] rawRes;
  logic         setBit;
  logic         ovfRaw;
  logic         msbCarryIn;
  logic         msbCarryOut;

  for (genvar i = 0; i < W; i++) begin : sliceGen
    logic cIn;
    logic cOut;
    logic sliceSum;
    logic lessIn;

    if (i == 0) begin : firstSlice
      assign cIn    = strobes.carryIn;
      assign lessIn = setBit;
    end else begin : innerSlice
      assign cIn    = sliceGen[i-1].cOut;
      assign lessIn = 1'b0;
    end

    alu_slice u_slice (
      .a       (a[i]),
      .b       (b[i]),
      .invA    (strobes.invA),
      .invB    (strobes.invB),
      .carryIn (cIn),
      .less    (lessIn),
      .sel     (strobes.sel),
      .sum     (sliceSum),
      .carryOut(cOut),
      .result  (rawRes[i])
    );
  end

  assign msbCarryIn  = sliceGen[MSB].cIn;
  assign msbCarryOut = sliceGen[MSB].cOut;
  assign ovfRaw      = msbCarryIn ^ msbCarryOut;
  // Sign of a-b, flipped when the subtraction overflowed
  assign setBit      = sliceGen[MSB].sliceSum ^ ovfRaw;

  assign result   = strobes.opValid ? rawRes : '0;
  assign zeroFlag = ~|result;
  assign carryOut = strobes.arith & msbCarryOut;
  assign overflow = strobes.arith & ovfRaw;

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   opCode,
  output logic [W-1:0] result,
  output logic         zeroFlag,
  output logic         carryOut,
  output logic         overflow
);

  ctrl_t strobes;

  alu_ctrl u_ctrl (
    .opCode (opCode),
    .strobes(strobes)
  );

  alu_datapath #(.W(W)) u_datapath (
    .a       (a),
    .b       (b),
    .strobes (strobes),
    .result  (result),
    .zeroFlag(zeroFlag),
    .carryOut(carryOut),
    .overflow(overflow)
  );

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [3:0]   opCode,
  input logic [W-1:0] result,
  input logic         zeroFlag,
  input logic         carryOut,
  input logic         overflow
);

  always_comb begin
    if (opCode == OP_AND) begin
      // R1
      and_result_chk: assert (result == (a & b)) else $error("and result");
    end
    if (opCode == OP_SUB) begin
      // R7
      sub_equal_chk: assert (zeroFlag == (a == b)) else $error("sub zero");
      // R4
      sub_borrow_chk: assert (carryOut == (a >= b)) else $error("sub carry");
    end
    if (opCode == OP_ADD) begin
      // R8
      add_ovf_chk: assert (overflow == ((a[W-1] == b[W-1]) && (result[W-1] != a[W-1])))
        else $error("add overflow");
    end
    if (opCode == OP_SLT) begin
      // R5
      slt_value_chk: assert (result == {{(W-1){1'b0}}, ($signed(a) < $signed(b))})
        else $error("slt value");
    end
    if (opCode inside {OP_AND, OP_OR, OP_SLT, OP_NOR}) begin
      // R10
      logic_flags_chk: assert (!carryOut && !overflow) else $error("logic flags");
    end
    if (!(opCode inside {OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NOR})) begin
      // R9
      unused_zero_chk: assert (result == '0 && !carryOut && !overflow)
        else $error("unused code");
    end
  end

endmodule

bind alu_core alu_core_chk #(.W(W)) u_chk (
  .a       (a),
  .b       (b),
  .opCode  (opCode),
  .result  (result),
  .zeroFlag(zeroFlag),
  .carryOut(carryOut),
  .overflow(overflow)
);

// File: tb/alu_core_tb.sv
`timescale 1ns/1ps
module alu_core_tb;

  localparam int W = 32;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, result;
  logic [3:0]   opCode;
  logic         zeroFlag, carryOut, overflow;

  int checkCount = 0;
  int passCount  = 0;
  bit done = 1'b0;

  alu_core #(.W(W)) u_dut (
    .a(a), .b(b), .opCode(opCode),
    .result(result), .zeroFlag(zeroFlag),
    .carryOut(carryOut), .overflow(overflow)
  );

  // {opCode, a, b, expected result}
  localparam logic [99:0] vecs [NV] = '{
    {4'h0, 32'hF0F0_1234, 32'hFF00_FF00, 32'hF000_1200},
    {4'h1, 32'h0F0F_0000, 32'h0000_00FF, 32'h0F0F_00FF},
    {4'h2, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C},
    {4'h2, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
    {4'h2, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000},
    {4'h6, 32'h0000_000A, 32'h0000_0003, 32'h0000_0007},
    {4'h6, 32'h0000_0003, 32'h0000_000A, 32'hFFFF_FFF9},
    {4'h6, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF},
    {4'h6, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000},
    {4'h7, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},
    {4'h7, 32'h0000_0005, 32'h0000_0002, 32'h0000_0000},
    {4'h7, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001},
    {4'h7, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000},
    {4'hC, 32'hF0F0_F0F0, 32'h0F0F_0000, 32'h0000_0F0F},
    {4'hC, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
    {4'h3, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000}
  };

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'h0: return "R1";
      4'h1: return "R2";
      4'h2: return "R3";
      4'h6: return "R4";
      4'h7: return "R5";
      4'hC: return "R6";
      default: return "R9";
    endcase
  endfunction

  // Behavioural flag model: {carry, overflow}
  function automatic logic [1:0] flagModel(input logic [3:0] op,
                                           input logic [W-1:0] x,
                                           input logic [W-1:0] y);
    logic [W:0] s;
    logic [W-1:0] r;
    if (op == 4'h2) begin
      s = {1'b0, x} + {1'b0, y};
      r = s[W-1:0];
      return {s[W], (x[W-1] == y[W-1]) && (r[W-1] != x[W-1])};
    end else if (op == 4'h6) begin
      s = {1'b0, x} + {1'b0, ~y} + {{W{1'b0}}, 1'b1};
      r = s[W-1:0];
      return {s[W], (x[W-1] != y[W-1]) && (r[W-1] != x[W-1])};
    end
    return 2'b00;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checkCount++;
    if (ok) passCount++;
    else $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
  endtask

  task automatic apply(input logic [3:0] op, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    opCode = op; a = x; b = y;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checkCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", passCount, checkCount);
      $finish;
    end
  end

  initial begin
    opCode = 4'h0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    #1;
    // Idle state: AND of zeros, R7 zero flag set, R10 no carry
    check(result == '0, "R1", "idle result", result, '0);
    check(zeroFlag == 1'b1, "R7", "idle zero", {31'b0, zeroFlag}, 1);
    check(!carryOut && !overflow, "R10", "idle flags", {30'b0, carryOut, overflow}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]   op;
      logic [W-1:0] x, y, e;
      logic [1:0]   fl;
      {op, x, y, e} = vecs[i];
      apply(op, x, y);
      fl = flagModel(op, x, y);
      check(result == e, tagOf(op), "result", result, e);
      check(zeroFlag == (e == '0), "R7", "zero flag", {31'b0, zeroFlag}, {31'b0, (e == '0)});
      check(carryOut == fl[1], (op == 4'h2 || op == 4'h6) ? tagOf(op) : "R10",
            "carry", {31'b0, carryOut}, {31'b0, fl[1]});
      check(overflow == fl[0], (op == 4'h2 || op == 4'h6) ? "R8" : "R10",
            "overflow", {31'b0, overflow}, {31'b0, fl[0]});
    end

    // R9 / R10 sweep of every code with operands that overflow and carry
    for (int c = 0; c < 16; c++) begin
      logic [3:0] op;
      logic [1:0] fl;
      op = 4'(c);
      apply(op, 32'h8765_4321, 32'h9ABC_DEF0);
      fl = flagModel(op, 32'h8765_4321, 32'h9ABC_DEF0);
      if (!(op inside {4'h0, 4'h1, 4'h2, 4'h6, 4'h7, 4'hC})) begin
        check(result == '0, "R9", "unused result", result, '0);
        check(!carryOut && !overflow, "R9", "unused flags", {30'b0, carryOut, overflow}, 0);
      end else begin
        check(carryOut == fl[1] && overflow == fl[0],
              (op == 4'h2 || op == 4'h6) ? "R8" : "R10", "sweep flags",
              {30'b0, carryOut, overflow}, {30'b0, fl});
      end
    end

    // R4 unsigned borrow sense: equal operands give carry 1
    apply(4'h6, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check(carryOut == 1'b1 && zeroFlag == 1'b1, "R4", "sub equal carry",
          {30'b0, carryOut, zeroFlag}, 32'd3);
    // R5 equal operands are not less
    apply(4'h7, 32'h8000_0000, 32'h8000_0000);
    check(result == '0, "R5", "slt equal", result, '0);
    // R2 all-ones OR
    apply(4'h1, 32'hAAAA_AAAA, 32'h5555_5555);
    check(result == 32'hFFFF_FFFF, "R2", "or complement", result, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", passCount, checkCount);
    $finish;
  end

endmodule